// File: doc/BRIEF.md
# Extended Hamming SECDED Encoder

This block turns a data word into a protected code block that a matching decoder can use to correct any single flipped bit and to flag any double flip. It is pure combinational logic: a new data word on the input shows up as a new code block on the output within the same cycle, with no clock, register or handshake. A surrounding design places it in front of a memory write port or a link transmitter and registers the result where its timing needs it.

The size is set by one parameter, `P`, the number of Hamming check bits. The block is always `2^P` bits long and carries `2^P - P - 1` data bits. One further bit, an overall even-parity bit, sits at index 0 and is counted in the block length but not in `P`. Legal values of `P` run from 2 (1 data bit in a 4-bit block) to 8 (247 data bits in a 256-bit block).

Top module: `secded_enc`

## Requirements
- R1: The output block is `2^P` bits wide and the data input is `2^P - P - 1` bits wide; the highest data bit lands in the highest block index, `2^P - 1`.
- R2: The output follows a change of the data input with no clock edge in between.
- R3: Data bits fill every block index that is neither 0 nor a power of two, in ascending order: data bit 0 at index 3, bit 1 at index 5, bit 2 at index 6, bit 3 at index 7, bit 4 at index 9, and so on.
- R4: For each k from 0 to P-1, block index `2^k` holds the XOR of every other block index whose binary form has bit k set.
- R5: The XOR of the indices of all set bits in any output block is zero (a zero syndrome).
- R6: Block index 0 is chosen so that the XOR of all `2^P` block bits is zero.
- R7: An all-zero data word gives an all-zero block.
- R8: Any two different data words give blocks that differ in at least four bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 2^P - P - 1 | Data word to protect |
| blk_o | output | 2^P | Code block: overall parity at index 0, check bits at power-of-two indices, data elsewhere |

## Verification
The hardest property to reach from the ports is the minimum distance of four, since it concerns pairs of words rather than one word at a time. The stimulus walks a single one and a single zero across every data position back to back, so consecutive blocks differ in one or two data bits, which is exactly where a wrong check-bit cover would drop the distance below four; random words fill in between. The combinational path is probed by changing the data halfway through a cycle and sampling before the next edge.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

  function automatic int unsigned blk_bits(input int unsigned p);
    return 32'd1 << p;
  endfunction

  function automatic int unsigned dat_bits(input int unsigned p);
    return (32'd1 << p) - p - 1;
  endfunction

  function automatic bit is_pow2(input int unsigned i);
    return (i != 0) && ((i & (i - 1)) == 0);
  endfunction

  // For a block index that is neither zero nor a power of two, the data bit
  // stored there: the index minus the number of check slots at or below it.
  function automatic int unsigned slot_to_dat(input int unsigned i);
    return i - $clog2(i + 1) - 1;
  endfunction

endpackage

// File: rtl/secded_scatter.sv
`timescale 1ns/1ps
module secded_scatter
  import secded_pkg::*;
#(
  parameter int unsigned P = 8,
  localparam int unsigned N = blk_bits(P),
  localparam int unsigned D = dat_bits(P)
) (
  input  logic [D-1:0] data_i,
  output logic [N-1:0] raw_o
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == 0 || is_pow2(i)) begin : g_chk
      assign raw_o[i] = 1'b0;
    end else begin : g_dat
      assign raw_o[i] = data_i[slot_to_dat(i)];
    end
  end

endmodule

// File: rtl/secded_hamming.sv
`timescale 1ns/1ps
module secded_hamming
  import secded_pkg::*;
#(
  parameter int unsigned P = 8,
  localparam int unsigned N = blk_bits(P)
) (
  input  logic [N-1:0] raw_i,
  output logic [P-1:0] par_o
);

  function automatic logic [N-1:0] cover_mask(input int unsigned k);
    logic [N-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (((i >> k) & 1) != 0 && i != (32'd1 << k)) m[i] = 1'b1;
    end
    return m;
  endfunction

  for (genvar k = 0; k < P; k++) begin : g_chk
    localparam logic [N-1:0] MASK = cover_mask(k);
    assign par_o[k] = ^(raw_i & MASK);
  end

endmodule

// File: rtl/secded_overall.sv
`timescale 1ns/1ps
module secded_overall #(
  parameter int unsigned N = 256
) (
  input  logic [N-1:1] body_i,
  output logic         par_o
);

  assign par_o = ^body_i;

endmodule

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc
  import secded_pkg::*;
#(
  parameter int unsigned P = 8,
  localparam int unsigned N = blk_bits(P),
  localparam int unsigned D = dat_bits(P)
) (
  input  logic [D-1:0] data_i,
  output logic [N-1:0] blk_o
);

  logic [N-1:0] raw;
  logic [P-1:0] chk;
  logic [N-1:0] body;
  logic         ovr;

  secded_scatter #(.P(P)) u_scatter (
    .data_i (data_i),
    .raw_o  (raw)
  );

  secded_hamming #(.P(P)) u_hamming (
    .raw_i (raw),
    .par_o (chk)
  );

  always_comb begin
    body = raw;
    for (int unsigned k = 0; k < P; k++) body[32'd1 << k] = chk[k];
  end

  secded_overall #(.N(N)) u_overall (
    .body_i (body[N-1:1]),
    .par_o  (ovr)
  );

  assign blk_o = {body[N-1:1], ovr};

  // R3
  always_comb begin
    int unsigned j;
    j = 0;
    for (int unsigned i = 3; i < N; i++) begin
      if (!is_pow2(i)) begin
        data_place_chk: assert (blk_o[i] == data_i[j]);
        j++;
      end
    end
  end

  // R5
  always_comb begin
    logic [P-1:0] syn;
    syn = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (blk_o[i]) syn = syn ^ P'(i);
    end
    syndrome_zero_chk: assert (syn == '0);
  end

  // R6
  always_comb begin
    even_block_chk: assert (^blk_o == 1'b0);
  end

  // R7
  always_comb begin
    if (data_i == '0) begin
      zero_map_chk: assert (blk_o == '0);
    end
  end

endmodule

// File: tb/secded_enc_test.sv
`timescale 1ns/1ps
module secded_enc_test;

  localparam int P = 8;
  localparam int N = 1 << P;
  localparam int D = N - P - 1;

  logic         clk;
  logic         rst;
  logic [D-1:0] din;
  logic [N-1:0] blk;

  int n_chk  = 0;
  int n_fail = 0;

  logic [N-1:0] prev_blk;
  logic [D-1:0] prev_din;
  bit           have_prev = 0;

  secded_enc #(.P(P)) uut (
    .data_i (din),
    .blk_o  (blk)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [N-1:0] model(input logic [D-1:0] d);
    logic [N-1:0] b;
    int j;
    b = '0;
    j = 0;
    for (int pos = 1; pos < N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        b[pos] = d[j];
        j++;
      end
    end
    for (int k = 0; k < P; k++) begin
      logic pb;
      pb = 0;
      for (int pos = 1; pos < N; pos++)
        if (((pos >> k) & 1) != 0 && pos != (1 << k)) pb ^= b[pos];
      b[1 << k] = pb;
    end
    b[0] = ^b[N-1:1];
    return b;
  endfunction

  function automatic logic [N-1:0] data_mask();
    logic [N-1:0] m;
    m = '0;
    for (int pos = 1; pos < N; pos++) if ((pos & (pos - 1)) != 0) m[pos] = 1;
    return m;
  endfunction

  function automatic logic [N-1:0] chk_mask();
    logic [N-1:0] m;
    m = '0;
    for (int k = 0; k < P; k++) m[1 << k] = 1;
    return m;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(input logic [D-1:0] d);
    logic [N-1:0] e;
    logic [N-1:0] dm;
    logic [N-1:0] cm;
    int syn;
    e  = model(d);
    dm = data_mask();
    cm = chk_mask();
    check((blk & dm) == (e & dm), "R3 data placement", blk & dm, e & dm);
    check((blk & cm) == (e & cm), "R4 check bits", blk & cm, e & cm);
    check(blk[0] == e[0] && (^blk) == 1'b0, "R6 overall parity", N'(blk[0]), N'(e[0]));
    syn = 0;
    for (int i = 0; i < N; i++) if (blk[i]) syn ^= i;
    check(syn == 0, "R5 syndrome", N'(syn), '0);
    if (d == '0) check(blk == '0, "R7 zero word", blk, '0);
    if (d[D-1]) check(blk[N-1] == 1'b1, "R1 top data bit at top index", N'(blk[N-1]), N'(1));
    if (have_prev && prev_din != d)
      check($countones(blk ^ prev_blk) >= 4, "R8 distance",
            N'($countones(blk ^ prev_blk)), N'(4));
    prev_blk  = blk;
    prev_din  = d;
    have_prev = 1;
  endtask

  task automatic apply(input logic [D-1:0] d);
    @(posedge clk);
    din = d;
    @(negedge clk);
    compare(d);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [D-1:0] r;
    logic [D-1:0] alt;
    rst = 1;
    din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero input, zero block (R7)
    check(blk == '0, "R7 reset state", blk, '0);
    rst = 0;

    // R1: only the top data bit set maps to exactly the top index plus its checks
    apply({1'b1, {(D-1){1'b0}}});
    check(blk == model({1'b1, {(D-1){1'b0}}}), "R1 top bit block",
          blk, model({1'b1, {(D-1){1'b0}}}));

    apply('0);
    apply('1);
    alt = '0;
    for (int i = 0; i < D; i += 2) alt[i] = 1;
    apply(alt);
    apply(~alt);

    // walking one then walking zero: neighbouring words for R8
    for (int i = 0; i < D; i++) apply(D'(1) << i);
    for (int i = 0; i < D; i++) apply(~(D'(1) << i));

    for (int n = 0; n < 300; n++) begin
      for (int w = 0; w < D; w += 32) begin
        logic [31:0] u;
        u = $urandom;
        for (int b = 0; b < 32 && w + b < D; b++) r[w + b] = u[b];
      end
      apply(r);
    end

    // R2: change mid-cycle, sample before any edge
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      #3;
      r = (n % 2 == 0) ? alt : ~din;
      din = r;
      #1;
      check(blk == model(r), "R2 combinational update", blk, model(r));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule